// File: doc/BRIEF.md
# Timer Channel Counter-Clock Gate

This block decides, cycle by cycle, whether one timer channel's counter advances. The selected input clock arrives as a one-cycle tick enable on the system clock. It becomes the counter clock only when two set/reset latches are both set. The first is the **enable** latch, which software commands control. The second is the **run** latch, which triggers control. The run latch responds only while the channel is enabled. A disabled channel can only be revived by a software enable command. The enable latch appears on a status output.

The channel holds a 16-bit up-counter, a compare value and a capture register, so the events that can stop or disable the clock automatically arise inside the block. A mode input selects capture or waveform behaviour. In capture mode, a rising edge on the B-side timer line copies the counter into the capture register, and that capture event may clear either latch under two option bits. In waveform mode, a compare match may clear either latch under two other option bits. Output waveform shaping, interrupt generation and register decoding belong to neighbouring blocks.

Top module: `tc_clock_gate`

## Requirements
- R1: `cnt_tick` is 1 exactly when `sel_tick`, `clk_status` and `running` are all 1. When no trigger is accepted, `count` increments by one on the edge after a cycle with `cnt_tick`=1 and otherwise holds. The counter wraps at its width.
- R2: The edge after `sw_enable`=1 sets `clk_status`, and the edge after `sw_disable`=1 clears it. When both commands are 1 in the same cycle, the disable takes effect. The enable latch holds when neither command is present.
- R3: While `clk_status` is 0, triggers have no effect: `running` and `count` do not change because of them. A trigger that arrives in the same cycle as `sw_enable` is also ignored. While disabled, `running` keeps its value.
- R4: Each of the four trigger inputs (`trig_sw`, `trig_sync`, `trig_ext`, `trig_cmp`) is accepted while `clk_status` is 1. On the next edge it sets `running` to 1 and sets `count` to 0.
- R5: In capture mode (`mode_wave`=0), `rb_load` pulses in the cycle where `tiob_in` is 1 after being 0 on the previous edge. On the following edge, `rb_value` takes the `count` value of that cycle. A `tiob_in` that stays high causes no further load. In waveform mode, `rb_load` stays 0 and `rb_value` holds.
- R6: In capture mode, an `rb_load` event clears `clk_status` on the next edge if `opt_dis_rb`=1, and clears `running` if `opt_stop_rb`=1. With an option bit at 0, the latch it controls is unaffected.
- R7: In waveform mode, `rc_match` is 1 in a cycle with `cnt_tick`=1 and `count`==`rc_value`. On the next edge, the event clears `clk_status` if `opt_dis_rc`=1, and clears `running` if `opt_stop_rc`=1. In capture mode, `rc_match` is 0 and the RC options have no effect.
- R8: An accepted trigger overrides an automatic stop in the same cycle, so `running` ends at 1. An automatic disable overrides `sw_enable` in the same cycle, so `clk_status` ends at 0.
- R9: `tioa_oe` and `tiob_oe` equal `mode_wave`. Both timer lines are inputs (0) in capture mode.
- R10: After a synchronous reset, `clk_status`, `running`, `count` and `rb_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_tick | input | 1 | Tick enable of the selected input clock |
| sw_enable | input | 1 | Software enable command pulse |
| sw_disable | input | 1 | Software disable command pulse |
| trig_sw | input | 1 | Software trigger |
| trig_sync | input | 1 | Synchro trigger shared between channels |
| trig_ext | input | 1 | External trigger |
| trig_cmp | input | 1 | Compare-derived trigger |
| mode_wave | input | 1 | 0 capture mode, 1 waveform mode |
| opt_dis_rb | input | 1 | Capture: disable the clock on a capture event |
| opt_stop_rb | input | 1 | Capture: stop the clock on a capture event |
| opt_dis_rc | input | 1 | Waveform: disable the clock on a compare match |
| opt_stop_rc | input | 1 | Waveform: stop the clock on a compare match |
| rc_value | input | 16 | Compare value |
| tiob_in | input | 1 | B-side timer line input |
| cnt_tick | output | 1 | Gated counter clock tick |
| count | output | 16 | Counter value |
| rb_value | output | 16 | Capture register |
| clk_status | output | 1 | Enable latch state |
| running | output | 1 | Run latch state |
| rc_match | output | 1 | Compare match event |
| rb_load | output | 1 | Capture event |
| tioa_oe | output | 1 | A-side line output enable |
| tiob_oe | output | 1 | B-side line output enable |

## Verification
The gated tick, `rc_match` and `rb_load` are combinational, so each is due in the cycle its inputs are applied. The bench reads them one nanosecond after driving those inputs, before the next rising edge. Latch states, `count` and `rb_value` change on the first edge after the stimulus, so the bench reads them one nanosecond after that edge. Option sweeps predict the counter by counting the ticks that were let through, and each check names the cycle in which it samples.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
    localparam int CNT_W  = 16;
    localparam int N_TRIG = 4;

    typedef struct packed {
        logic en;
        logic run;
    } gate_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
    } ctr_t;
endpackage

// File: rtl/tcg_edge_det.sv
module tcg_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_in;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end

    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/tcg_gate_latches.sv
module tcg_gate_latches
    import tcg_pkg::*;
#(
    parameter int NT = N_TRIG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_en,
    input  logic          cmd_dis,
    input  logic [NT-1:0] trig_vec,
    input  logic          auto_dis,
    input  logic          auto_stop,
    output logic          en,
    output logic          run,
    output logic          trig_hit
);
    gate_t g_d, g_q;
    logic  any_trig;

    always_comb begin
        any_trig = |trig_vec;
        trig_hit = any_trig & g_q.en;
        g_d      = g_q;
        // enable latch: any disable source beats the enable command
        if (cmd_dis || auto_dis)  g_d.en = 1'b0;
        else if (cmd_en)          g_d.en = 1'b1;
        // run latch only responds while enabled; trigger beats auto stop
        if (g_q.en) begin
            if (any_trig)         g_d.run = 1'b1;
            else if (auto_stop)   g_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    assign en  = g_q.en;
    assign run = g_q.run;
endmodule

// File: rtl/tcg_counter.sv
module tcg_counter
    import tcg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clear,
    input  logic         cap_evt,
    input  logic         cmp_on,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         cmp_evt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        cmp_evt = tick & cmp_on & (s_q.cnt == cmp_val);
        if (clear)     s_d.cnt = '0;
        else if (tick) s_d.cnt = s_q.cnt + ONE;
        if (cap_evt)   s_d.cap = s_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign cap = s_q.cap;
endmodule

// File: rtl/tc_clock_gate.sv
module tc_clock_gate
    import tcg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_tick,
    input  logic         sw_enable,
    input  logic         sw_disable,
    input  logic         trig_sw,
    input  logic         trig_sync,
    input  logic         trig_ext,
    input  logic         trig_cmp,
    input  logic         mode_wave,
    input  logic         opt_dis_rb,
    input  logic         opt_stop_rb,
    input  logic         opt_dis_rc,
    input  logic         opt_stop_rc,
    input  logic [W-1:0] rc_value,
    input  logic         tiob_in,
    output logic         cnt_tick,
    output logic [W-1:0] count,
    output logic [W-1:0] rb_value,
    output logic         clk_status,
    output logic         running,
    output logic         rc_match,
    output logic         rb_load,
    output logic         tioa_oe,
    output logic         tiob_oe
);
    logic [N_TRIG-1:0] trig_vec;
    logic en, run, trig_hit, b_rise, auto_dis, auto_stop;

    always_comb begin
        trig_vec  = {trig_cmp, trig_ext, trig_sync, trig_sw};
        cnt_tick  = sel_tick & en & run;
        rb_load   = b_rise & ~mode_wave;
        auto_dis  = (rb_load & opt_dis_rb)  | (rc_match & opt_dis_rc);
        auto_stop = (rb_load & opt_stop_rb) | (rc_match & opt_stop_rc);
        tioa_oe   = mode_wave;
        tiob_oe   = mode_wave;
    end

    tcg_edge_det u_edge (
        .clk(clk), .rst(rst), .sig_in(tiob_in), .rise(b_rise)
    );

    tcg_gate_latches #(.NT(N_TRIG)) u_gate (
        .clk(clk), .rst(rst),
        .cmd_en(sw_enable), .cmd_dis(sw_disable),
        .trig_vec(trig_vec), .auto_dis(auto_dis), .auto_stop(auto_stop),
        .en(en), .run(run), .trig_hit(trig_hit)
    );

    tcg_counter #(.W(W)) u_ctr (
        .clk(clk), .rst(rst), .tick(cnt_tick), .clear(trig_hit),
        .cap_evt(rb_load), .cmp_on(mode_wave), .cmp_val(rc_value),
        .cnt(count), .cap(rb_value), .cmp_evt(rc_match)
    );

    assign clk_status = en;
    assign running    = run;
endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         sel_tick,
    input logic         sw_disable,
    input logic         any_trig,
    input logic         mode_wave,
    input logic         cnt_tick,
    input logic [W-1:0] count,
    input logic [W-1:0] rb_value,
    input logic         clk_status,
    input logic         running,
    input logic         rc_match,
    input logic         rb_load
);
    // R1
    tick_needs_latches_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |-> (clk_status && running && sel_tick));
    // R1
    hold_when_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !(any_trig && clk_status)) |=> $stable(count));
    // R2
    disable_wins_chk: assert property (@(posedge clk) disable iff (rst)
        sw_disable |=> !clk_status);
    // R3
    run_frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_status |=> (running == $past(running)));
    // R4
    trigger_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_status && any_trig) |=> (running && count == '0));
    // R5
    no_capture_in_wave_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wave |-> !rb_load);
    // R5
    capture_value_chk: assert property (@(posedge clk) disable iff (rst)
        rb_load |=> (rb_value == $past(count)));
    // R7
    match_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rc_match |-> (cnt_tick && mode_wave));
endmodule

bind tc_clock_gate tcg_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .sel_tick(sel_tick), .sw_disable(sw_disable),
    .any_trig(trig_sw | trig_sync | trig_ext | trig_cmp),
    .mode_wave(mode_wave), .cnt_tick(cnt_tick), .count(count),
    .rb_value(rb_value), .clk_status(clk_status), .running(running),
    .rc_match(rc_match), .rb_load(rb_load)
);

// File: tb/tb_tc_clock_gate.sv
module tb_tc_clock_gate;
    localparam int W = 16;
    logic clk = 1'b0;
    logic rst;
    logic sel_tick, sw_enable, sw_disable;
    logic trig_sw, trig_sync, trig_ext, trig_cmp;
    logic mode_wave, opt_dis_rb, opt_stop_rb, opt_dis_rc, opt_stop_rc;
    logic [W-1:0] rc_value;
    logic tiob_in;
    logic cnt_tick, clk_status, running, rc_match, rb_load, tioa_oe, tiob_oe;
    logic [W-1:0] count, rb_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tc_clock_gate dut (
        .clk(clk), .rst(rst), .sel_tick(sel_tick),
        .sw_enable(sw_enable), .sw_disable(sw_disable),
        .trig_sw(trig_sw), .trig_sync(trig_sync), .trig_ext(trig_ext),
        .trig_cmp(trig_cmp), .mode_wave(mode_wave),
        .opt_dis_rb(opt_dis_rb), .opt_stop_rb(opt_stop_rb),
        .opt_dis_rc(opt_dis_rc), .opt_stop_rc(opt_stop_rc),
        .rc_value(rc_value), .tiob_in(tiob_in),
        .cnt_tick(cnt_tick), .count(count), .rb_value(rb_value),
        .clk_status(clk_status), .running(running), .rc_match(rc_match),
        .rb_load(rb_load), .tioa_oe(tioa_oe), .tiob_oe(tiob_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clear_pulses();
        sw_enable = 0; sw_disable = 0;
        trig_sw = 0; trig_sync = 0; trig_ext = 0; trig_cmp = 0;
    endtask

    task automatic do_reset();
        clear_pulses();
        sel_tick = 1; tiob_in = 0; rst = 1;
        step(); step();
        rst = 0;
    endtask

    task automatic start_chan();
        sw_enable = 1; step(); sw_enable = 0;
        trig_sw = 1; step(); trig_sw = 0;
    endtask

    task automatic fire(input int idx);
        case (idx)
            0: trig_sw   = 1;
            1: trig_sync = 1;
            2: trig_ext  = 1;
            default: trig_cmp = 1;
        endcase
    endtask

    initial begin
        int t;
        int exp_cnt;
        rc_value = 16'd5;
        mode_wave = 0; opt_dis_rb = 0; opt_stop_rb = 0; opt_dis_rc = 0; opt_stop_rc = 0;
        sel_tick = 0;
        do_reset();
        // R10 reset state
        chk("R10 status", clk_status, 0);
        chk("R10 running", running, 0);
        chk("R10 count", count, 0);
        chk("R10 rb_value", rb_value, 0);

        // R9 output enables follow mode
        for (int m = 0; m < 2; m++) begin
            mode_wave = m[0]; settle();
            chk("R9 tioa_oe", tioa_oe, m);
            chk("R9 tiob_oe", tiob_oe, m);
        end
        mode_wave = 0;

        // R3 trigger while never enabled
        trig_ext = 1; step(); trig_ext = 0;
        chk("R3 running after trigger while off", running, 0);
        chk("R3 count after trigger while off", count, 0);
        // R3 trigger together with enable is ignored
        sw_enable = 1; trig_sw = 1; step(); clear_pulses();
        chk("R2 enable sets status", clk_status, 1);
        chk("R3 trigger with enable ignored", running, 0);

        // R2 simultaneous enable and disable
        sw_enable = 1; sw_disable = 1; step(); clear_pulses();
        chk("R2 disable wins", clk_status, 0);
        sw_enable = 1; step(); clear_pulses();
        step();
        chk("R2 status holds", clk_status, 1);
        sw_disable = 1; step(); clear_pulses();
        chk("R2 disable clears", clk_status, 0);

        // R1 tick gating with a pattern on sel_tick
        do_reset();
        start_chan();
        chk("R1 start count", count, 0);
        exp_cnt = 0;
        for (int k = 0; k < 24; k++) begin
            sel_tick = (k % 3 != 0); settle();
            chk("R1 cnt_tick follows sel_tick", cnt_tick, (k % 3 != 0) ? 1 : 0);
            if (k % 3 != 0) exp_cnt++;
            step();
        end
        chk("R1 count equals passed ticks", count, exp_cnt);
        sel_tick = 1;
        sw_disable = 1; step(); clear_pulses();
        exp_cnt++;
        settle();
        chk("R1 no tick when disabled", cnt_tick, 0);
        step(); step();
        chk("R1 count holds when disabled", count, exp_cnt);
        // R3 trigger while disabled does not clear count
        trig_sync = 1; step(); clear_pulses();
        chk("R3 count kept on trigger while off", count, exp_cnt);
        chk("R3 running kept while off", running, 1);
        sw_enable = 1; step(); clear_pulses();
        settle();
        chk("R1 re-enabled resumes tick", cnt_tick, 1);

        // R4 each trigger source
        for (int i = 0; i < 4; i++) begin
            do_reset();
            start_chan();
            step(); step(); step();
            chk("R4 pre-trigger count", count, 3);
            fire(i); step(); clear_pulses();
            chk("R4 count cleared by trigger", count, 0);
            chk("R4 running after trigger", running, 1);
            step();
            chk("R4 counting after trigger", count, 1);
        end

        // R5 R6 R7 sweep over mode and all option bits
        for (int cfg = 0; cfg < 32; cfg++) begin
            int m, drb, srb, drc, src, en1, run1, en2, run2, cnt1;
            m = cfg[4]; drb = cfg[0]; srb = cfg[1]; drc = cfg[2]; src = cfg[3];
            mode_wave = m[0]; opt_dis_rb = drb[0]; opt_stop_rb = srb[0];
            opt_dis_rc = drc[0]; opt_stop_rc = src[0];
            rc_value = 16'd5;
            do_reset();
            start_chan();
            for (int k = 0; k < 5; k++) step();
            settle();
            chk("R7 rc_match at compare", rc_match, m);
            step();
            en1  = (m == 1 && drc == 1) ? 0 : 1;
            run1 = (m == 1 && src == 1) ? 0 : 1;
            chk("R7 status after compare", clk_status, en1);
            chk("R7 running after compare", running, run1);
            chk("R7 count after compare", count, 6);
            tiob_in = 1; settle();
            chk("R5 rb_load on rising edge", rb_load, 1 - m);
            step();
            cnt1 = 6 + ((en1 == 1 && run1 == 1) ? 1 : 0);
            if (m == 0) begin
                en2  = drb ? 0 : 1;
                run2 = srb ? 0 : 1;
            end else begin
                en2 = en1; run2 = run1;
            end
            chk("R5 rb_value after edge", rb_value, (m == 0) ? 6 : 0);
            chk("R6 status after capture", clk_status, en2);
            chk("R6 running after capture", running, run2);
            chk("R6 count after capture", count, cnt1);
            settle();
            chk("R5 no reload on steady high", rb_load, 0);
            tiob_in = 0;
        end

        // R8 trigger beats auto stop in the same cycle
        mode_wave = 1; opt_dis_rb = 0; opt_stop_rb = 0; opt_dis_rc = 0; opt_stop_rc = 1;
        rc_value = 16'd2;
        do_reset();
        start_chan();
        step(); step();
        trig_ext = 1; settle();
        chk("R8 compare present with trigger", rc_match, 1);
        step(); clear_pulses();
        chk("R8 trigger wins over stop", running, 1);
        chk("R8 count cleared", count, 0);
        // R8 auto disable beats sw_enable in the same cycle
        opt_stop_rc = 0; opt_dis_rc = 1;
        do_reset();
        start_chan();
        step(); step();
        sw_enable = 1; step(); clear_pulses();
        chk("R8 auto disable wins over enable", clk_status, 0);
        // R7 no compare event without a tick
        do_reset();
        start_chan();
        step(); step();
        sel_tick = 0; settle();
        chk("R7 no match without tick", rc_match, 0);
        step();
        chk("R7 status kept without tick", clk_status, 1);
        sel_tick = 1;

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule